// File: doc/BRIEF.md
# Sticky Display Interrupt Controller

This block connects the vertical-blank event of a video controller to the interrupt line of a host bus. When a frame's blanking period begins, the block records a pending flag. It records the flag only if the display controller's own interrupt enable is set. The flag stays set until software writes to a dedicated clear address. Reading the flag does not clear it.

A second enable bit, held at board level in the block's own register, decides whether the pending flag drives the host interrupt line. Software polls a status register to find out why the line is asserted.

A build-time parameter selects one of two register layouts. The address offsets, the enable bit position and the status encoding all depend on the layout. Only the low 16 address bits are decoded.

The register port is a plain single-cycle strobe interface with no back-pressure. A write is taken on every clock edge where the write strobe is high. Read data is a combinational function of the address. Every input and output of the block is a plain control or status pin, so no valid/ready handshake is used.

Top module: `disp_irq_glue`

## Requirements
- R1: When `vblank_pulse` is high at a clock edge and `vid_irq_en` is 1, the pending flag is 1 after that edge.
- R2: A `vblank_pulse` taken while `vid_irq_en` is 0 leaves the pending flag unchanged.
- R3: `host_irq` is high exactly when the board enable is 1 and the pending flag is 1.
- R4: A write to the enable register loads the board enable from the selected data bit. That bit is bit 0 at offset 0x204C in layout 0, and bit 5 at offset 0x2000 in layout 1. All other data bits are ignored.
- R5: Any write to the clear offset clears the pending flag, whatever the data value. The clear offset is 0x2054 in layout 0 and 0x2008 in layout 1.
- R6: In layout 0, a read at offset 0x2044 returns 0x4 while the flag is pending and 0 otherwise. Every other offset reads as 0.
- R7: Address bits above bit 15 are ignored for every read and write decode.
- R8: When a counted vblank event and a clear write occur in the same cycle, the flag is 1 afterwards.
- R9: After reset, the pending flag and the board enable are both 0, `host_irq` is 0 and status reads return 0.
- R10: In layout 1, a read at any address with bit 14 set returns 0x80 while the flag is pending and 0 otherwise. Every other address reads as 0.
- R11: Without a clear write, the pending flag holds its value. Writes to any other offset do not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address; only bits 15:0 are decoded |
| reg_wr | input | 1 | Write strobe, one write per cycle while high |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| vblank_pulse | input | 1 | Start of vertical blanking, one-cycle pulse |
| vid_irq_en | input | 1 | Display controller interrupt enable (control bit 0) |
| host_irq | output | 1 | Interrupt request to the host bus |

## Verification
The hardest case to reach is the same-cycle collision of a counted vblank and a clear write. A close second is a clear or enable write that arrives while a flag is already pending.

The bench reaches both with a sweep. For each layout, it loads every combination of prior pending state and board enable through the register port. It then applies every combination of vblank, controller enable and clear write in one single cycle. The expected status and interrupt values are computed arithmetically from the inputs.

Separate passes cover the following:
- upper address bits set on every decode;
- writes whose data masks out the enable bit;
- writes to neighbouring offsets, which must leave the flag untouched.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  localparam int LOW_W = 16;

  function automatic logic [15:0] en_offset(input int variant);
    return (variant == 1) ? 16'h2000 : 16'h204C;
  endfunction

  function automatic int en_bit(input int variant);
    return (variant == 1) ? 5 : 0;
  endfunction

  function automatic logic [15:0] clr_offset(input int variant);
    return (variant == 1) ? 16'h2008 : 16'h2054;
  endfunction

  function automatic logic [15:0] stat_offset(input int variant);
    return (variant == 1) ? 16'h4000 : 16'h2044;
  endfunction

  function automatic logic [7:0] stat_code(input int variant);
    return (variant == 1) ? 8'h80 : 8'h04;
  endfunction

endpackage

// File: rtl/dirq_decode.sv
module dirq_decode #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int VARIANT = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_load,
  output logic              en_value,
  output logic              clr_hit,
  output logic              stat_sel
);
  import disp_irq_pkg::*;

  localparam logic [15:0] EN_OFF  = en_offset(VARIANT);
  localparam int          EN_BIT  = en_bit(VARIANT);
  localparam logic [15:0] CLR_OFF = clr_offset(VARIANT);
  localparam logic [15:0] ST_OFF  = stat_offset(VARIANT);

  logic [LOW_W-1:0] a16;
  logic             wdata_unused;

  assign a16          = addr[LOW_W-1:0];
  assign wdata_unused = ^wdata;
  assign en_load      = wr && (a16 == EN_OFF);
  assign en_value     = wdata[EN_BIT];
  assign clr_hit      = wr && (a16 == CLR_OFF);

  generate
    if (VARIANT == 1) begin : g_probe_bit
      assign stat_sel = a16[14];
    end else begin : g_probe_exact
      assign stat_sel = (a16 == ST_OFF);
    end
  endgenerate
endmodule

// File: rtl/dirq_pending.sv
module dirq_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= 1'b0;
    else if (set_ev) pend <= 1'b1;   // event outranks a same-cycle clear
    else if (clr)    pend <= 1'b0;
  end
endmodule

// File: rtl/dirq_enable.sv
module dirq_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 1'b0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/disp_irq_glue.sv
module disp_irq_glue #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vblank_pulse,
  input  logic              vid_irq_en,
  output logic              host_irq
);
  import disp_irq_pkg::*;

  localparam logic [DATA_W-1:0] ST_VAL = DATA_W'(stat_code(VARIANT));

  logic en_load, en_value, clr_hit, stat_sel;
  logic pend_q, ben_q;

  dirq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VARIANT(VARIANT)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .en_load(en_load), .en_value(en_value), .clr_hit(clr_hit), .stat_sel(stat_sel)
  );

  dirq_pending u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_ev(vblank_pulse && vid_irq_en), .clr(clr_hit), .pend(pend_q)
  );

  dirq_enable u_ben (
    .clk(clk), .rst_n(rst_n), .ld(en_load), .d(en_value), .q(ben_q)
  );

  assign host_irq  = ben_q && pend_q;
  assign reg_rdata = (stat_sel && pend_q) ? ST_VAL : '0;
endmodule

// File: rtl/dirq_checker.sv
module dirq_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int VARIANT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              vblank_pulse,
  input logic              vid_irq_en,
  input logic              host_irq,
  input logic              pend,
  input logic              ben
);
  import disp_irq_pkg::*;

  localparam logic [15:0] EN_OFF  = en_offset(VARIANT);
  localparam int          EN_BIT  = en_bit(VARIANT);
  localparam logic [15:0] CLR_OFF = clr_offset(VARIANT);

  logic ev, clr_w, en_w;
  assign ev    = vblank_pulse && vid_irq_en;
  assign clr_w = reg_wr && (reg_addr[15:0] == CLR_OFF);
  assign en_w  = reg_wr && (reg_addr[15:0] == EN_OFF);

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n) ev |=> pend);
  p_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !ev) |=> !pend);
  p_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && ben && !en_w) |=> host_irq);
  p_en_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_w |=> (ben == $past(reg_wdata[EN_BIT])));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !ev) |=> !pend);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_w) |=> pend);
endmodule

bind disp_irq_glue dirq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VARIANT(VARIANT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .vblank_pulse(vblank_pulse), .vid_irq_en(vid_irq_en), .host_irq(host_irq),
  .pend(pend_q), .ben(ben_q)
);

// File: tb/test_disp_irq_glue.sv
`timescale 1ns/1ps
module test_disp_irq_glue;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [31:0] b_addr  [2];
  logic [31:0] b_wdata [2];
  logic        b_wr    [2];
  logic        b_vb    [2];
  logic        b_ven   [2];
  logic [31:0] rd      [2];
  logic        irq     [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  disp_irq_glue #(.VARIANT(0)) i_disp_irq_glue (
    .clk(clk), .rst_n(rst_n), .reg_addr(b_addr[0]), .reg_wr(b_wr[0]),
    .reg_wdata(b_wdata[0]), .reg_rdata(rd[0]), .vblank_pulse(b_vb[0]),
    .vid_irq_en(b_ven[0]), .host_irq(irq[0])
  );

  disp_irq_glue #(.VARIANT(1)) i_disp_irq_glue_alt (
    .clk(clk), .rst_n(rst_n), .reg_addr(b_addr[1]), .reg_wr(b_wr[1]),
    .reg_wdata(b_wdata[1]), .reg_rdata(rd[1]), .vblank_pulse(b_vb[1]),
    .vid_irq_en(b_ven[1]), .host_irq(irq[1])
  );

  // per-layout constants, taken from the requirements
  function automatic logic [31:0] en_a(int m);  return m ? 32'h2000 : 32'h204C; endfunction
  function automatic logic [31:0] en_m(int m);  return m ? 32'h20 : 32'h1;      endfunction
  function automatic logic [31:0] clr_a(int m); return m ? 32'h2008 : 32'h2054; endfunction
  function automatic logic [31:0] st_a(int m);  return m ? 32'h4000 : 32'h2044; endfunction
  function automatic logic [31:0] st_v(int m);  return m ? 32'h80 : 32'h4;      endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int m);
    b_wr[m] = 0; b_vb[m] = 0; b_ven[m] = 0; b_addr[m] = st_a(m); b_wdata[m] = 0;
  endtask

  task automatic wr(int m, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    b_addr[m] = a; b_wdata[m] = d; b_wr[m] = 1;
    @(negedge clk);
    idle(m);
  endtask

  task automatic vblank(int m, logic ven);
    @(negedge clk);
    b_vb[m] = 1; b_ven[m] = ven;
    @(negedge clk);
    idle(m);
  endtask

  task automatic sample(int m, string req, logic exp_p, logic exp_b);
    b_addr[m] = st_a(m);
    #1;
    check(req, rd[m], exp_p ? st_v(m) : 32'h0);
    check({req, "/R3"}, {31'b0, irq[m]}, {31'b0, exp_p & exp_b});
  endtask

  task automatic sweep(int m);
    string pre;
    pre = m ? "R10/" : "R6/";
    for (int prior = 0; prior < 2; prior++)
      for (int be = 0; be < 2; be++)
        for (int cmb = 0; cmb < 8; cmb++) begin
          logic vb, ven, cl, exp_p;
          string req;
          vb = cmb[0]; ven = cmb[1]; cl = cmb[2];
          wr(m, en_a(m), be ? en_m(m) : 32'h0);
          if (prior) vblank(m, 1'b1); else wr(m, clr_a(m), 32'h0);
          @(negedge clk);
          b_vb[m] = vb; b_ven[m] = ven;
          if (cl) begin
            b_wr[m] = 1; b_addr[m] = clr_a(m); b_wdata[m] = 32'h5A00_0000 | 32'(cmb * 37 + prior);
          end
          @(negedge clk);
          idle(m);
          exp_p = (vb & ven) | (prior[0] & ~cl);
          if (vb & ven & cl)  req = "R8";
          else if (vb & ven)  req = "R1";
          else if (cl)        req = "R5";
          else if (vb)        req = "R2";
          else                req = "R11";
          sample(m, {pre, req}, exp_p, be[0]);
        end
  endtask

  task automatic extras(int m);
    string pre;
    pre = m ? "R10/" : "R6/";
    // R7: upper address bits ignored on enable, clear and status decode
    wr(m, en_a(m) | 32'hABCD_0000, en_m(m));
    vblank(m, 1'b1);
    sample(m, {pre, "R7"}, 1'b1, 1'b1);
    b_addr[m] = st_a(m) | 32'h7700_0000; #1;
    check({pre, "R7 status"}, rd[m], st_v(m));
    wr(m, clr_a(m) | 32'hFFFF_0000, 32'hFFFF_FFFF);
    sample(m, {pre, "R7 clear"}, 1'b0, 1'b1);
    // R4: data with the enable bit clear but every other bit set disables
    vblank(m, 1'b1);
    wr(m, en_a(m), ~en_m(m));
    sample(m, {pre, "R4 masked"}, 1'b1, 1'b0);
    wr(m, en_a(m), en_m(m));
    sample(m, {pre, "R4 set"}, 1'b1, 1'b1);
    // R11: neighbouring offsets do not clear
    wr(m, clr_a(m) + 4, 32'hFFFF_FFFF);
    wr(m, clr_a(m) - 4, 32'hFFFF_FFFF);
    sample(m, {pre, "R11 neighbour"}, 1'b1, 1'b1);
    // status decode: non-status addresses read 0 while pending
    b_addr[m] = en_a(m); #1;
    check(m ? "R10 other addr" : "R6 other addr", rd[m], 32'h0);
    b_addr[m] = m ? 32'h3FFC : 32'h2040; #1;
    check(m ? "R10 other addr" : "R6 other addr", rd[m], 32'h0);
    if (m == 1) begin
      b_addr[1] = 32'h0000_C123; #1;
      check("R10 bit14 probe", rd[1], 32'h80);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle(0); idle(1);
    b_vb[0] = 1; b_ven[0] = 1; b_vb[1] = 1; b_ven[1] = 1; // must be ignored in reset
    repeat (3) @(negedge clk);
    rst_n = 1; idle(0); idle(1);
    for (int m = 0; m < 2; m++) sample(m, "R9 reset", 1'b0, 1'b0);
    // R9: after reset the enable is 0: a pending flag must not raise irq
    vblank(0, 1'b1);
    sample(0, "R9 enable", 1'b1, 1'b0);
    for (int m = 0; m < 2; m++) begin
      sweep(m);
      extras(m);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule